// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a 16-bit virtual address onto a 16-bit physical address through a small on-chip table of segment descriptors. Each descriptor has a base, a limit and a valid flag. A request gives either a virtual address alone or a virtual address plus an explicit segment number. The block picks a descriptor and checks the offset against that descriptor's limit. It then adds the offset to the base. A result comes back one clock later as either a physical address or a fault with a reason code.

The descriptor table is loaded through a write port. Only a write marked as kernel-mode is accepted. A write marked as user-mode leaves the table as it was and raises a flag for one cycle. The table has eight entries by default. The segment field in the virtual address reaches only the first four entries; the explicit segment number reaches all of them. After reset, entries 0 to 3 hold a default layout and are valid, and entries 4 to 7 are invalid.

Top module: `seg_xlate_unit`

## Requirements
- R1: When `req_seg_sel` is 0, bits 15:14 of `req_vaddr` select the descriptor. In every case, bits 13:0 form the offset.
- R2: A legal request produces `pa_valid`=1 one cycle later, with `pa_addr` = base + offset.
- R3: An offset greater than or equal to the descriptor's limit gives `fault`=1 with `fault_code`=2'b10 and `pa_valid`=0.
- R4: A request to a descriptor whose valid flag is clear gives `fault`=1 with `fault_code`=2'b01. This code takes priority over a bounds fault.
- R5: When `req_seg_sel` is 1, `req_seg` selects the descriptor, and any of the eight entries can be reached this way.
- R6: Reset loads this table (index: base/limit): 0: 0x4000/0x0800, 1: 0x4800/0x1400, 2: 0xF000/0x1000, 3: 0x0000/0x3000. These four entries are valid; entries 4 to 7 are invalid.
- R7: A write with `cfg_we`=1 and `cfg_kernel`=1 replaces entry `cfg_idx`. Requests issued from the following cycle onward see the new base, limit and valid flag.
- R8: A write with `cfg_we`=1 and `cfg_kernel`=0 changes no entry. It raises `cfg_denied` for exactly the next cycle.
- R9: `pa_valid` and `fault` are never both high. Both stay low in any cycle after a cycle with `req_valid`=0.
- R10: While `rst` is high, `pa_valid`, `fault`, `fault_code` and `cfg_denied` are 0.
- R11: The base + offset sum wraps modulo 2^16, and a wrap raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 16 | Virtual address |
| req_seg_sel | input | 1 | 1: use `req_seg` as the segment number |
| req_seg | input | 3 | Explicit segment number |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_kernel | input | 1 | Write issued in kernel mode |
| cfg_idx | input | 3 | Descriptor index written |
| cfg_base | input | 16 | New base |
| cfg_limit | input | 16 | New limit |
| cfg_valid | input | 1 | New valid flag |
| pa_valid | output | 1 | Physical address valid (registered) |
| pa_addr | output | 16 | Physical address (registered) |
| fault | output | 1 | Translation fault (registered) |
| fault_code | output | 2 | 01 invalid segment, 10 out of bounds |
| cfg_denied | output | 1 | User-mode write rejected (registered pulse) |

## Verification
The checker assumes that `req_vaddr`, `req_seg` and the write inputs are stable at each rising edge, and that `cfg_idx` and `req_seg` stay below the table depth. The stimulus changes every input only on the falling edge. It uses only indices 0 to 7 against the eight-entry default table. It never issues a request and a write to the same entry in the same cycle, so the bench never depends on the read-before-write order inside one cycle.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_INVALID = 2'b01,
    FLT_BOUNDS  = 2'b10
  } flt_code_e;
endpackage

// File: rtl/sat_table.sv
module sat_table #(
  parameter int NUM_SEGS = 8,
  parameter int ADDR_W   = 16,
  localparam int IDX_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_kernel,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_limit,
  input  logic              wr_valid,
  output logic              wr_denied,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] rd_limit,
  output logic              rd_valid
);
  logic [ADDR_W-1:0] base_q  [NUM_SEGS];
  logic [ADDR_W-1:0] limit_q [NUM_SEGS];
  logic [NUM_SEGS-1:0] vld_q;

  function automatic logic [ADDR_W-1:0] dflt_base(input int i);
    case (i)
      0:       return ADDR_W'(16'h4000);
      1:       return ADDR_W'(16'h4800);
      2:       return ADDR_W'(16'hF000);
      default: return '0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] dflt_limit(input int i);
    case (i)
      0:       return ADDR_W'(16'h0800);
      1:       return ADDR_W'(16'h1400);
      2:       return ADDR_W'(16'h1000);
      3:       return ADDR_W'(16'h3000);
      default: return '0;
    endcase
  endfunction

  logic wr_ok;
  assign wr_ok     = wr_en && wr_kernel;
  assign wr_denied = wr_en && !wr_kernel;

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g]  <= dflt_base(g);
        limit_q[g] <= dflt_limit(g);
        vld_q[g]   <= (g < 4);
      end else if (wr_ok && (wr_idx == IDX_W'(g))) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
        vld_q[g]   <= wr_valid;
      end
    end
  end

  always_comb begin
    rd_base  = '0;
    rd_limit = '0;
    rd_valid = 1'b0;
    if (int'(rd_idx) < NUM_SEGS) begin
      rd_base  = base_q[rd_idx];
      rd_limit = limit_q[rd_idx];
      rd_valid = vld_q[rd_idx];
    end
  end
endmodule

// File: rtl/sat_check.sv
module sat_check
  import sat_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 14
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic              seg_ok,
  output logic [ADDR_W-1:0] phys,
  output flt_code_e         code
);
  logic [ADDR_W-1:0] off_ext;
  logic              in_range;

  assign off_ext  = ADDR_W'(offset);
  assign in_range = off_ext < limit;
  assign phys     = base + off_ext;

  always_comb begin
    if (!seg_ok)        code = FLT_INVALID;
    else if (!in_range) code = FLT_BOUNDS;
    else                code = FLT_NONE;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import sat_pkg::*;
#(
  parameter int NUM_SEGS   = 8,
  parameter int ADDR_W     = 16,
  parameter int VA_SEG_W   = 2,
  localparam int IDX_W     = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1,
  localparam int OFF_W     = ADDR_W - VA_SEG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_seg_sel,
  input  logic [IDX_W-1:0]  req_seg,
  input  logic              cfg_we,
  input  logic              cfg_kernel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic              cfg_valid,
  output logic              pa_valid,
  output logic [ADDR_W-1:0] pa_addr,
  output logic              fault,
  output logic [1:0]        fault_code,
  output logic              cfg_denied
);
  logic [VA_SEG_W-1:0] va_seg;
  logic [OFF_W-1:0]    va_off;
  logic [IDX_W-1:0]    sel_idx;
  logic [ADDR_W-1:0]   ent_base, ent_limit, sum;
  logic                ent_valid, deny_c;
  flt_code_e           code_c;

  assign va_seg  = req_vaddr[ADDR_W-1 -: VA_SEG_W];
  assign va_off  = req_vaddr[OFF_W-1:0];
  assign sel_idx = req_seg_sel ? req_seg : IDX_W'(va_seg);

  sat_table #(.NUM_SEGS(NUM_SEGS), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_kernel(cfg_kernel), .wr_idx(cfg_idx),
    .wr_base(cfg_base), .wr_limit(cfg_limit), .wr_valid(cfg_valid),
    .wr_denied(deny_c),
    .rd_idx(sel_idx), .rd_base(ent_base), .rd_limit(ent_limit),
    .rd_valid(ent_valid)
  );

  sat_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_check (
    .offset(va_off), .base(ent_base), .limit(ent_limit),
    .seg_ok(ent_valid), .phys(sum), .code(code_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_valid   <= 1'b0;
      pa_addr    <= '0;
      fault      <= 1'b0;
      fault_code <= FLT_NONE;
      cfg_denied <= 1'b0;
    end else begin
      cfg_denied <= deny_c;
      pa_valid   <= req_valid && (code_c == FLT_NONE);
      fault      <= req_valid && (code_c != FLT_NONE);
      fault_code <= req_valid ? code_c : FLT_NONE;
      if (req_valid && (code_c == FLT_NONE)) pa_addr <= sum;
    end
  end
endmodule

// File: rtl/seg_xlate_unit_chk.sv
module seg_xlate_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       cfg_we,
  input logic       cfg_kernel,
  input logic       pa_valid,
  input logic       fault,
  input logic [1:0] fault_code,
  input logic       cfg_denied
);
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pa_valid && fault)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!pa_valid && !fault)); // R9
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    fault |-> (fault_code == 2'b01 || fault_code == 2'b10)); // R4
  AST_USER_DENY: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_kernel) |=> cfg_denied); // R8
  AST_KERNEL_OK: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && !cfg_kernel) |=> !cfg_denied); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!pa_valid && !fault && !cfg_denied)); // R10
endmodule

bind seg_xlate_unit seg_xlate_unit_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .cfg_we(cfg_we),
  .cfg_kernel(cfg_kernel), .pa_valid(pa_valid), .fault(fault),
  .fault_code(fault_code), .cfg_denied(cfg_denied)
);

// File: tb/seg_xlate_unit_tb.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb;
  logic clk = 0, rst = 1;
  logic req_valid = 0, req_seg_sel = 0;
  logic [15:0] req_vaddr = 0;
  logic [2:0] req_seg = 0, cfg_idx = 0;
  logic cfg_we = 0, cfg_kernel = 0, cfg_valid = 0;
  logic [15:0] cfg_base = 0, cfg_limit = 0;
  logic pa_valid, fault, cfg_denied;
  logic [15:0] pa_addr;
  logic [1:0] fault_code;

  always #2.5 clk = ~clk;

  seg_xlate_unit u_dut (.*);

  typedef struct {
    logic pv; logic flt; logic [1:0] code; logic [15:0] addr; logic den; string tag;
  } exp_t;
  exp_t q[$];
  int errors = 0, checks = 0;

  logic [15:0] m_base[8], m_lim[8];
  logic        m_vld[8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [15:0] va, input logic sel, input logic [2:0] sg, input string tag);
    exp_t e;
    logic [2:0] idx;
    logic [15:0] off;
    idx = sel ? sg : {1'b0, va[15:14]};
    off = {2'b00, va[13:0]};
    e.tag = tag; e.den = 0; e.addr = m_base[idx] + off;
    if (!m_vld[idx])          begin e.pv = 0; e.flt = 1; e.code = 2'b01; end
    else if (off >= m_lim[idx]) begin e.pv = 0; e.flt = 1; e.code = 2'b10; end
    else                      begin e.pv = 1; e.flt = 0; e.code = 2'b00; end
    @(negedge clk);
    cfg_we = 0; req_valid = 1; req_vaddr = va; req_seg_sel = sel; req_seg = sg;
    q.push_back(e);
  endtask

  task automatic wr(input logic kern, input logic [2:0] i, input logic [15:0] b,
                    input logic [15:0] l, input logic v, input string tag);
    exp_t e;
    e.tag = tag; e.pv = 0; e.flt = 0; e.code = 0; e.addr = 0; e.den = !kern;
    @(negedge clk);
    req_valid = 0; cfg_we = 1; cfg_kernel = kern; cfg_idx = i;
    cfg_base = b; cfg_limit = l; cfg_valid = v;
    q.push_back(e);
    if (kern) begin m_base[i] = b; m_lim[i] = l; m_vld[i] = v; end
  endtask

  task automatic idle(input string tag);
    exp_t e;
    e.tag = tag; e.pv = 0; e.flt = 0; e.code = 0; e.addr = 0; e.den = 0;
    @(negedge clk);
    req_valid = 0; cfg_we = 0; req_vaddr = 16'h0123;
    q.push_back(e);
  endtask

  // monitor: compares one scoreboard item after each edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " pa_valid"}, 32'(pa_valid), 32'(e.pv));
        chk({e.tag, " fault"}, 32'(fault), 32'(e.flt));
        chk({e.tag, " fault_code"}, 32'(fault_code), 32'(e.code));
        chk({e.tag, " cfg_denied"}, 32'(cfg_denied), 32'(e.den));
        if (e.pv) chk({e.tag, " pa_addr"}, 32'(pa_addr), 32'(e.addr));
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R6 model of reset table
    m_base[0] = 16'h4000; m_lim[0] = 16'h0800;
    m_base[1] = 16'h4800; m_lim[1] = 16'h1400;
    m_base[2] = 16'hF000; m_lim[2] = 16'h1000;
    m_base[3] = 16'h0000; m_lim[3] = 16'h3000;
    for (int i = 0; i < 8; i++) begin
      if (i >= 4) begin m_base[i] = 0; m_lim[i] = 0; end
      m_vld[i] = (i < 4);
    end
    req_valid = 1; cfg_we = 1; cfg_kernel = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset pa_valid", 32'(pa_valid), 0);
    chk("R10 reset fault", 32'(fault), 0);
    chk("R10 reset cfg_denied", 32'(cfg_denied), 0);
    @(negedge clk); rst = 0; req_valid = 0; cfg_we = 0;

    req(16'h0240, 0, 0, "R1 R2 seg0 0x0240");
    req(16'h4050, 0, 0, "R1 R2 seg1 0x4050");
    req(16'h07FF, 0, 0, "R3 seg0 last legal");
    req(16'h0800, 0, 0, "R3 seg0 offset==limit");
    req(16'hFFFF, 0, 0, "R3 seg3 over limit");
    req(16'h8FFF, 0, 0, "R2 seg2 top");
    idle("R9 idle");
    req(16'h0050, 1, 3'd1, "R5 explicit seg1");
    req(16'h0010, 1, 3'd5, "R4 R6 explicit seg5 invalid");
    wr(0, 3'd5, 16'h1000, 16'h0100, 1, "R8 user write");
    req(16'hC010, 1, 3'd5, "R8 seg5 still invalid");
    wr(1, 3'd5, 16'h1000, 16'h0100, 1, "R7 kernel write");
    req(16'hC010, 1, 3'd5, "R7 seg5 new entry");
    req(16'h0100, 1, 3'd5, "R3 seg5 offset==limit");
    wr(1, 3'd2, 16'hF800, 16'h1000, 1, "R7 rebase seg2");
    req(16'h8900, 0, 0, "R11 wrap");
    wr(1, 3'd0, 16'h4000, 16'h0800, 0, "R7 invalidate seg0");
    req(16'h0000, 0, 0, "R4 seg0 invalid");
    req(16'h3FFF, 0, 0, "R4 invalid beats bounds");
    req(16'h4050, 1, 3'd7, "R5 R6 explicit seg7 invalid");
    idle("R9 idle tail");
    idle("R9 idle tail2");
    repeat (3) @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule